// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block divides each nominal CAN bit into time quanta and marks the moments that the rest of a CAN controller needs. A prescaler outside the block supplies a one-cycle time-quantum tick. The block counts those ticks through a one-quantum sync segment, a combined propagation and phase-1 stretch, and a phase-2 stretch. It then emits a bit-start pulse, a transmit-point pulse, and a sample pulse together with the sampled bus value.

The block follows the bus in two ways. While the hard-sync enable is high (bus idle or waiting for start of frame), any recessive-to-dominant transition on the receive line restarts the bit. In that case the quantum in which the edge is seen counts as the sync segment. Otherwise the block resynchronizes: an early edge stretches phase 1 and a late edge cuts phase 2, each bounded by the jump width. All four segment lengths are programmable and are clamped into their legal ranges before use.

Top module: `can_bit_timing`

## Requirements
- R1: The propagation length and phase-1 length inputs are each used clamped to 1..8 quanta; a value of 0 acts as 1 and values above 8 act as 8.
- R2: The phase-2 length input is used clamped to the range from max(effective phase 1, 2) up to 8 quanta, 2 quanta being the fixed information processing time.
- R3: The jump width input is used clamped to the range from 1 up to min(effective phase 1, 4) quanta.
- R4: With no falling edge on rx (rx 1 is recessive, 0 is dominant), a bit-start pulse occurs on every Nth tick, where N = 1 + prop + ph1 + ph2 (effective values). A sample pulse occurs on the tick that lies prop + ph1 ticks after each bit-start tick. Every pulse is high for the one clock cycle following the rising clock edge on which tq_tick was high.
- R5: With hard_sync_en high, a tick that sees rx at 0 after rx was 1 at the previous tick gives a bit-start pulse on that tick, with no transmit-point pulse. The next sample pulse follows prop + ph1 ticks later.
- R6: With hard_sync_en low, an edge seen e ticks after the sync quantum and no later than the sample tick delays the sample pulse, and the following bit start, by min(e, SJW) ticks.
- R7: With hard_sync_en low, an edge seen in phase 2 with r phase-2 quanta left (counting the current one) does one of two things. If r <= SJW, a new bit (bit start and transmit point) starts on that tick. Otherwise phase 2 is shortened by SJW ticks.
- R8: Only recessive-to-dominant transitions act. A falling edge seen in the sync quantum with hard_sync_en low is ignored. At most one resynchronization is applied between two sample points.
- R9: bit_o takes the value of rx at each sample tick and holds it until the next sample pulse.
- R10: After reset, all pulse outputs are 0, bit_o is 1, and the first tick is a sync quantum (bit start and transmit point).
- R11: The pulses are one clock wide, appear only after a tick, sample never coincides with bit start, and a transmit point always coincides with a bit start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_tick | input | 1 | One-cycle time-quantum enable from the prescaler |
| rx | input | 1 | Synchronized receive line, 1 recessive, 0 dominant |
| hard_sync_en | input | 1 | High while hard synchronization is allowed (bus idle) |
| prop_len | input | SEG_W | Propagation segment length in quanta |
| ph1_len | input | SEG_W | Phase segment 1 length in quanta |
| ph2_len | input | SEG_W | Phase segment 2 length in quanta |
| sjw_len | input | SEG_W | Resynchronization jump width in quanta |
| sample_o | output | 1 | Sample-point pulse |
| bit_o | output | 1 | Bus value taken at the last sample point |
| bit_start_o | output | 1 | Start-of-bit pulse (sync quantum) |
| tx_point_o | output | 1 | Transmit-point pulse |

## Verification
A wrong segment counter or a wrong clamp shows up as a bit-start or sample pulse on the wrong tick, so the fault appears within one bit time, at most 25 ticks. A wrong phase-1 stretch or phase-2 cut caused by an edge moves the very next sample or bit start, so edge placement is swept across every quantum of the bit with random lengths. A resynchronization flag that is not cleared, or one that is applied twice, changes where the sample lands in the same bit or the next one. This is exercised by a second edge placed before the sample point, and by edges that fall on the sync quantum.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_TS1  = 2'd1,
      SEG_TS2  = 2'd2
   } seg_e;

   function automatic int unsigned clamp_len(input int unsigned v,
                                             input int unsigned lo,
                                             input int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
   import can_bt_pkg::*;
#(
   parameter int unsigned SEG_W       = 4,
   parameter int unsigned PROP_MAX    = 8,
   parameter int unsigned PH1_MAX     = 8,
   parameter int unsigned PH2_MAX     = 8,
   parameter int unsigned SJW_MAX     = 4,
   parameter int unsigned IPT_TQ      = 2,
   parameter bit          PH2_DERIVED = 1'b0,
   parameter int unsigned CNT_W       = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEG_W-1:0] prop_i,
   input  logic [SEG_W-1:0] ph1_i,
   input  logic [SEG_W-1:0] ph2_i,
   input  logic [SEG_W-1:0] sjw_i,
   output logic [CNT_W-1:0] t1_o,
   output logic [CNT_W-1:0] ph2_o,
   output logic [CNT_W-1:0] sjw_o
);

   int unsigned prop_v;
   int unsigned ph1_v;
   int unsigned ph2_v;
   int unsigned sjw_v;
   int unsigned floor_v;
   int unsigned cap_v;

   always_comb begin
      prop_v  = clamp_len(32'(prop_i), 1, PROP_MAX);
      ph1_v   = clamp_len(32'(ph1_i), 1, PH1_MAX);
      floor_v = max_u(ph1_v, IPT_TQ);
      cap_v   = min_u(ph1_v, SJW_MAX);
      sjw_v   = clamp_len(32'(sjw_i), 1, cap_v);
   end

   generate
      if (PH2_DERIVED) begin : g_ph2_derived
         assign ph2_v = floor_v;
      end else begin : g_ph2_prog
         assign ph2_v = clamp_len(32'(ph2_i), floor_v, PH2_MAX);
      end
   endgenerate

   assign t1_o  = CNT_W'(prop_v + ph1_v);
   assign ph2_o = CNT_W'(ph2_v);
   assign sjw_o = CNT_W'(sjw_v);

   // R1: effective lengths stay in their legal windows
   p_len_range_r1: assert property (@(posedge clk) disable iff (rst)
      (prop_v >= 1) && (prop_v <= PROP_MAX) && (ph1_v >= 1) && (ph1_v <= PH1_MAX));

   // R2: phase 2 never shorter than phase 1 or the processing time
   p_ph2_floor_r2: assert property (@(posedge clk) disable iff (rst)
      (ph2_v >= ph1_v) && (ph2_v >= IPT_TQ) && (ph2_v <= PH2_MAX));

   // R3: jump width bounded by phase 1 and by its own maximum
   p_sjw_cap_r3: assert property (@(posedge clk) disable iff (rst)
      (sjw_v >= 1) && (sjw_v <= ph1_v) && (sjw_v <= SJW_MAX));

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic rx_i,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst)         prev_q <= 1'b1;
      else if (tick_i) prev_q <= rx_i;
   end

   assign fall_o = tick_i & prev_q & ~rx_i;

   // R8: a reported edge always leaves the tracked level dominant
   p_fall_tracks_r8: assert property (@(posedge clk) disable iff (rst)
      fall_o |=> !prev_q);

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             fall_i,
   input  logic             hs_en_i,
   input  logic             rx_i,
   input  logic [CNT_W-1:0] t1_i,
   input  logic [CNT_W-1:0] ph2_i,
   input  logic [CNT_W-1:0] sjw_i,
   output logic             sample_o,
   output logic             bit_o,
   output logic             start_o,
   output logic             tx_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seg_e             seg_q, seg_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] ext_q, ext_n;
   logic [CNT_W-1:0] shr_q, shr_n;
   logic             rdone_q, rdone_n;
   logic             bit_q, bit_n;
   logic             samp_n, start_n, tx_n;
   logic [CNT_W-1:0] err1;
   logic [CNT_W-1:0] rem2;

   always_comb begin
      seg_n   = seg_q;
      cnt_n   = cnt_q;
      ext_n   = ext_q;
      shr_n   = shr_q;
      rdone_n = rdone_q;
      bit_n   = bit_q;
      samp_n  = 1'b0;
      start_n = 1'b0;
      tx_n    = 1'b0;
      err1    = ((cnt_q + ONE) < sjw_i) ? (cnt_q + ONE) : sjw_i;
      rem2    = ph2_i - cnt_q;
      if (tick_i) begin
         if (fall_i && hs_en_i) begin
            start_n = 1'b1;
            seg_n   = SEG_TS1;
            cnt_n   = '0;
            ext_n   = '0;
            shr_n   = '0;
            rdone_n = 1'b0;
         end else begin
            unique case (seg_q)
               SEG_SYNC: begin
                  start_n = 1'b1;
                  tx_n    = 1'b1;
                  seg_n   = SEG_TS1;
                  cnt_n   = '0;
                  ext_n   = '0;
                  shr_n   = '0;
               end
               SEG_TS1: begin
                  if (fall_i && !rdone_q) begin
                     ext_n   = err1;
                     rdone_n = 1'b1;
                  end
                  if (cnt_q == (t1_i - ONE + ext_n)) begin
                     samp_n  = 1'b1;
                     bit_n   = rx_i;
                     seg_n   = SEG_TS2;
                     cnt_n   = '0;
                     ext_n   = '0;
                     rdone_n = 1'b0;
                  end else begin
                     cnt_n = cnt_q + ONE;
                  end
               end
               SEG_TS2: begin
                  if (fall_i && !rdone_q && (rem2 <= sjw_i)) begin
                     start_n = 1'b1;
                     tx_n    = 1'b1;
                     seg_n   = SEG_TS1;
                     cnt_n   = '0;
                     ext_n   = '0;
                     shr_n   = '0;
                     rdone_n = 1'b1;
                  end else begin
                     if (fall_i && !rdone_q) begin
                        shr_n   = sjw_i;
                        rdone_n = 1'b1;
                     end
                     if (cnt_q == (ph2_i - ONE - shr_n)) begin
                        seg_n = SEG_SYNC;
                        cnt_n = '0;
                        shr_n = '0;
                     end else begin
                        cnt_n = cnt_q + ONE;
                     end
                  end
               end
               default: seg_n = SEG_SYNC;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_q    <= SEG_SYNC;
         cnt_q    <= '0;
         ext_q    <= '0;
         shr_q    <= '0;
         rdone_q  <= 1'b0;
         bit_q    <= 1'b1;
         sample_o <= 1'b0;
         start_o  <= 1'b0;
         tx_o     <= 1'b0;
      end else begin
         seg_q    <= seg_n;
         cnt_q    <= cnt_n;
         ext_q    <= ext_n;
         shr_q    <= shr_n;
         rdone_q  <= rdone_n;
         bit_q    <= bit_n;
         sample_o <= samp_n;
         start_o  <= start_n;
         tx_o     <= tx_n;
      end
   end

   assign bit_o = bit_q;

   // R11: pulses only follow a quantum tick
   p_pulse_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
      (sample_o || start_o) |-> $past(tick_i));

   // R11: sample point and bit start are distinct quanta
   p_excl_r11: assert property (@(posedge clk) disable iff (rst)
      !(sample_o && start_o));

   // R7: transmit point only at a bit start
   p_tx_at_start_r7: assert property (@(posedge clk) disable iff (rst)
      tx_o |-> start_o);

   // R9: sampled value changes only with a sample pulse
   p_bit_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !sample_o |-> $stable(bit_o));

   // R6: phase-1 stretch never exceeds the jump width
   p_ext_sjw_r6: assert property (@(posedge clk) disable iff (rst)
      ext_q <= sjw_i);

   // R7: phase-2 cut never exceeds the jump width
   p_shr_sjw_r7: assert property (@(posedge clk) disable iff (rst)
      shr_q <= sjw_i);

   // R8: once a resync is taken, the stretch is frozen until the flag clears
   p_single_resync_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(rdone_q) && rdone_q) |-> $stable(ext_q));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
   import can_bt_pkg::*;
#(
   parameter int unsigned SEG_W       = 4,
   parameter int unsigned PROP_MAX    = 8,
   parameter int unsigned PH1_MAX     = 8,
   parameter int unsigned PH2_MAX     = 8,
   parameter int unsigned SJW_MAX     = 4,
   parameter int unsigned IPT_TQ      = 2,
   parameter bit          PH2_DERIVED = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tq_tick,
   input  logic             rx,
   input  logic             hard_sync_en,
   input  logic [SEG_W-1:0] prop_len,
   input  logic [SEG_W-1:0] ph1_len,
   input  logic [SEG_W-1:0] ph2_len,
   input  logic [SEG_W-1:0] sjw_len,
   output logic             sample_o,
   output logic             bit_o,
   output logic             bit_start_o,
   output logic             tx_point_o
);

   localparam int unsigned BIT_MAX = 1 + PROP_MAX + PH1_MAX + SJW_MAX + PH2_MAX;
   localparam int unsigned CNT_W   = $clog2(BIT_MAX + 1);
   localparam int unsigned IN_MAX  = (1 << SEG_W) - 1;

   generate
      if (PROP_MAX < 1 || PH1_MAX < 1 || SJW_MAX < 1 || IPT_TQ < 1) begin : g_chk_min
         $error("segment maxima and processing time must be at least one quantum");
      end
      if (PH2_MAX < PH1_MAX || PH2_MAX < IPT_TQ) begin : g_chk_ph2
         $error("phase 2 maximum must cover phase 1 maximum and processing time");
      end
      if (PROP_MAX > IN_MAX || PH1_MAX > IN_MAX || PH2_MAX > IN_MAX || SJW_MAX > IN_MAX) begin : g_chk_w
         $error("length input width too narrow for the configured maxima");
      end
   endgenerate

   logic [CNT_W-1:0] t1_w;
   logic [CNT_W-1:0] ph2_w;
   logic [CNT_W-1:0] sjw_w;
   logic             fall_w;

   can_bt_cfg #(
      .SEG_W      (SEG_W),
      .PROP_MAX   (PROP_MAX),
      .PH1_MAX    (PH1_MAX),
      .PH2_MAX    (PH2_MAX),
      .SJW_MAX    (SJW_MAX),
      .IPT_TQ     (IPT_TQ),
      .PH2_DERIVED(PH2_DERIVED),
      .CNT_W      (CNT_W)
   ) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .prop_i(prop_len),
      .ph1_i (ph1_len),
      .ph2_i (ph2_len),
      .sjw_i (sjw_len),
      .t1_o  (t1_w),
      .ph2_o (ph2_w),
      .sjw_o (sjw_w)
   );

   can_bt_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .tick_i(tq_tick),
      .rx_i  (rx),
      .fall_o(fall_w)
   );

   can_bt_seq #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tq_tick),
      .fall_i  (fall_w),
      .hs_en_i (hard_sync_en),
      .rx_i    (rx),
      .t1_i    (t1_w),
      .ph2_i   (ph2_w),
      .sjw_i   (sjw_w),
      .sample_o(sample_o),
      .bit_o   (bit_o),
      .start_o (bit_start_o),
      .tx_o    (tx_point_o)
   );

endmodule

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tq  = 1'b0;
   logic       rx  = 1'b1;
   logic       hs  = 1'b0;
   logic [3:0] prop = 4'd2, ph1 = 4'd3, ph2 = 4'd3, sjw = 4'd1;
   logic       sample_o, bit_o, bit_start_o, tx_point_o;

   int  n_tests  = 0;
   int  n_fail   = 0;
   int  pulse_err = 0;
   bit  finished = 1'b0;
   logic c_s, c_b, c_t, c_bo;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_bit_timing dut (
      .clk         (clk),
      .rst         (rst),
      .tq_tick     (tq),
      .rx          (rx),
      .hard_sync_en(hs),
      .prop_len    (prop),
      .ph1_len     (ph1),
      .ph2_len     (ph2),
      .sjw_len     (sjw),
      .sample_o    (sample_o),
      .bit_o       (bit_o),
      .bit_start_o (bit_start_o),
      .tx_point_o  (tx_point_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int clampi(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction
   function automatic int maxi(input int a, input int b); return (a > b) ? a : b; endfunction
   function automatic int mini(input int a, input int b); return (a < b) ? a : b; endfunction

   function automatic int e_prop(input int v); return clampi(v, 1, 8); endfunction
   function automatic int e_ph1(input int v);  return clampi(v, 1, 8); endfunction
   function automatic int e_ph2(input int v, input int a); return clampi(v, maxi(a, 2), 8); endfunction
   function automatic int e_sjw(input int v, input int a); return clampi(v, 1, mini(a, 4)); endfunction

   function automatic logic rx_at(input int k, input int k1, input int k2, input int k3);
      if (k < k1) return 1'b1;
      if (k < k2) return 1'b0;
      if (k < k3) return 1'b1;
      return 1'b0;
   endfunction

   task automatic do_reset(input int p, input int a, input int b, input int j, input bit h);
      @(negedge clk);
      rst = 1'b1; tq = 1'b0; rx = 1'b1; hs = h;
      prop = p[3:0]; ph1 = a[3:0]; ph2 = b[3:0]; sjw = j[3:0];
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic step(input logic v);
      @(negedge clk);
      tq = 1'b1; rx = v;
      @(negedge clk);
      tq = 1'b0;
      c_s = sample_o; c_b = bit_start_o; c_t = tx_point_o; c_bo = bit_o;
      if (c_s && c_b) pulse_err++;
      if (c_t && !c_b) pulse_err++;
      @(negedge clk);
      if (sample_o || bit_start_o || tx_point_o) pulse_err++;
   endtask

   task automatic run_nominal(input int p, input int a, input int b, input int j,
                              input int nbits, input int low_until, input string req);
      int t1, n, bad, first;
      t1 = e_prop(p) + e_ph1(a);
      n  = 1 + t1 + e_ph2(b, e_ph1(a));
      bad = 0; first = -1;
      do_reset(p, a, b, j, 1'b0);
      for (int k = 0; k < n * nbits; k++) begin
         step((k < low_until) ? 1'b0 : 1'b1);
         if (c_s != ((k % n) == t1) || c_b != ((k % n) == 0) || c_t != ((k % n) == 0)) begin
            bad++;
            if (first < 0) first = k;
         end
      end
      check(bad == 0, req, "nominal pulse pattern, first bad tick", first, -1);
   endtask

   task automatic run_edges(input int p, input int a, input int b, input int j, input bit h,
                            input int k1, input int k2, input int k3,
                            input int ets, input int etb, input int etx, input string req);
      int n, ts, tb, txv, bo, lim;
      n = 1 + e_prop(p) + e_ph1(a) + e_ph2(b, e_ph1(a));
      ts = -1; tb = -1; txv = -1; bo = -1;
      lim = k1 + 3 * n;
      do_reset(p, a, b, j, h);
      for (int k = 0; k < lim; k++) begin
         step(rx_at(k, k1, k2, k3));
         if (k >= k1 && c_s && ts < 0) begin ts = k; bo = int'(c_bo); end
         if (k >= k1 && c_b && tb < 0) begin tb = k; txv = int'(c_t); end
      end
      check(ts == ets, req, "sample tick", ts, ets);
      check(tb == etb, req, "bit start tick", tb, etb);
      check(txv == etx, req, "transmit point at bit start", txv, etx);
      if (ts >= 0) check(bo == int'(rx_at(ts, k1, k2, k3)), "R9", "sampled bit", bo,
                         int'(rx_at(ts, k1, k2, k3)));
   endtask

   task automatic run_single(input int p, input int a, input int b, input int j,
                             input bit h, input int k);
      int t1, be, je, n, ts, tb, tx, rem;
      string req;
      t1 = e_prop(p) + e_ph1(a);
      be = e_ph2(b, e_ph1(a));
      je = e_sjw(j, e_ph1(a));
      n  = 1 + t1 + be;
      if (h) begin
         tb = k; ts = k + t1; tx = 0; req = "R5";
      end else if (k <= t1) begin
         ts = t1 + mini(k, je); tb = ts + be + 1; tx = 1; req = "R6";
      end else if (k < n) begin
         rem = n - k; tx = 1; req = "R7";
         if (rem <= je) begin tb = k; ts = k + t1; end
         else begin tb = t1 + be - je + 1; ts = tb + t1; end
      end else begin
         tb = n; ts = n + t1; tx = 1; req = "R8";
      end
      run_edges(p, a, b, j, h, k, 1 << 20, 1 << 20, ts, tb, tx, req);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset(2, 3, 3, 1, 1'b0);
      // R10 reset state
      check(sample_o == 1'b0 && bit_start_o == 1'b0 && tx_point_o == 1'b0, "R10",
            "pulses after reset", int'({sample_o, bit_start_o, tx_point_o}), 0);
      check(bit_o == 1'b1, "R10", "bit_o after reset", int'(bit_o), 1);
      step(1'b1);
      check(c_b && c_t && !c_s, "R10", "first tick is sync", int'({c_s, c_b, c_t}), 3);

      // R4 nominal timing
      run_nominal(2, 3, 3, 1, 3, 0, "R4");
      run_nominal(8, 8, 8, 4, 2, 0, "R4");
      // R1 clamping of prop and phase 1
      run_nominal(0, 15, 0, 15, 2, 0, "R1");
      run_nominal(15, 0, 4, 1, 2, 0, "R1");
      // R2 phase 2 floor and ceiling
      run_nominal(3, 1, 1, 1, 3, 0, "R2");
      run_nominal(2, 5, 1, 3, 2, 0, "R2");
      run_nominal(1, 2, 15, 1, 2, 0, "R2");
      // R8 sync-quantum edge and rising edges ignored
      run_nominal(2, 3, 3, 1, 3, 4, "R8");

      // R5 hard sync
      run_single(3, 4, 3, 2, 1'b1, 5);
      run_single(3, 4, 3, 2, 1'b1, 9);
      // R6 lengthening, R3 jump width clamp
      run_single(4, 4, 4, 2, 1'b0, 2);
      run_single(2, 2, 4, 9, 1'b0, 4);
      run_single(2, 2, 4, 0, 1'b0, 3);
      // R7 shortening both ways
      run_single(3, 3, 6, 2, 1'b0, 8);
      run_single(3, 3, 6, 2, 1'b0, 12);
      // R8 edge in sync quantum
      run_single(3, 3, 6, 2, 1'b0, 13);
      // R8 second edge before sample point ignored
      run_edges(4, 4, 4, 2, 1'b0, 2, 3, 4, 10, 15, 1, "R8");

      // random sweep
      for (int i = 0; i < 40; i++) begin
         int p, a, b, j, n, k;
         bit h;
         p = int'($urandom_range(0, 15));
         a = int'($urandom_range(0, 15));
         b = int'($urandom_range(0, 15));
         j = int'($urandom_range(0, 15));
         h = ($urandom_range(0, 3) == 0);
         n = 1 + e_prop(p) + e_ph1(a) + e_ph2(b, e_ph1(a));
         k = int'($urandom_range(1, n));
         run_single(p, a, b, j, h, k);
      end

      check(pulse_err == 0, "R11", "pulse width and exclusivity errors", pulse_err, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule